// File: doc/BRIEF.md
# Serial-Loaded Latched Output Controller

This block switches eight on/off channel enables from a three-wire serial stream made of a serial clock, a data line and a latch strobe. Each serial clock rise moves one data bit into a shift register. A latch rise copies the whole shift register into a holding register. The holding register drives the channel outputs. Because loading and display are separate, a host can stream in a new pattern while the old one stays lit, and the new pattern then appears all at once.

Two gating inputs can override the held pattern. A shutdown input turns every channel off and can be toggled as a PWM dimming signal. An over-temperature flag also turns every channel off, and operation resumes by itself when the flag clears. The last stage of the shift register comes out on a serial output that changes only on the falling edge of the serial clock. Several controllers can therefore be chained on a shared clock and latch, and the downstream device still gets setup margin.

All serial and control inputs are asynchronous. They pass through two-flop synchronizers into a system clock that runs at least eight times faster than the serial clock, and edges are detected after synchronization.

Top module: `ser_chan_ctrl`

## Requirements
- R1: Each detected rising edge of `sclk_i` shifts the shift register one place toward its top bit and loads the synchronized `sdata_i` into bit 0. This holds for serial clock high and low phases of at least four system clocks each.
- R2: Bits arrive most significant first. Of eight bits shifted in, the first ends up controlling `chan_on_o[7]` and the last controls `chan_on_o[0]`.
- R3: The holding register changes only on a detected rising edge of `latch_i`. Serial clocks without a latch leave `chan_on_o` unchanged.
- R4: A held 1 drives its `chan_on_o` bit high (channel on) and a held 0 drives it low (off). A newly latched pattern is visible on `chan_on_o` by the fourth system clock edge after `latch_i` rises.
- R5: While `rst_n` is low, the shift register, holding register, `chan_on_o` and `sdata_o` are all zero. A latch after reset with no shifting in between therefore yields all channels off.
- R6: While `shdn_i` is high, `chan_on_o` is all zero from the third system clock edge after it rises. When `shdn_i` falls, the held pattern returns within three edges and the holding register keeps its contents.
- R7: While `hot_i` is high, `chan_on_o` is all zero. When it clears, the held pattern returns by itself. While `shdn_i` is high the flag has no further effect.
- R8: `sdata_o` equals the top bit of the shift register and changes only on a detected falling edge of `sclk_i`.
- R9: When a serial clock rise and a latch rise are detected in the same system cycle, the holding register takes the shift register value from before that cycle's shift.
- R10: With two controllers chained (first device's `sdata_o` feeding the second device's `sdata_i`, clock and latch shared), 16 serial clocks followed by one latch load 16 channels. The first bit sent lands on `chan_on_o[7]` of the second device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous clear of all registers |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdata_i | input | 1 | Serial data, sampled on serial clock rise |
| latch_i | input | 1 | Latch strobe; rise copies shift register to holding register |
| shdn_i | input | 1 | Shutdown, high forces all channels off |
| hot_i | input | 1 | Over-temperature flag, high forces all channels off |
| chan_on_o | output | NUM_CH | Channel enables, 1 = on |
| sdata_o | output | 1 | Cascade output, shift register top bit, updated on serial clock fall |

## Verification
The checker enforces the following on every cycle: the one-place shift on each detected clock rise, the stability of the holding register between latch rises, the pre-shift load when clock and latch rise together, the all-off output one cycle after either synchronized gate is high, and the serial output changing only on a clock fall. Some behaviour is visible only through the bench's scenarios. This covers the MSB-first mapping of a full byte onto channels, the end-to-end latencies from the asynchronous pins, the restoration of the pattern after a PWM-style shutdown pulse or a cleared temperature flag, and the 16-bit load of two chained controllers.

// File: rtl/ser_chan_pkg.sv
package ser_chan_pkg;

   // bit positions inside the synchronized input vector
   localparam int IDX_SCLK  = 0;
   localparam int IDX_DATA  = 1;
   localparam int IDX_LATCH = 2;
   localparam int IDX_SHDN  = 3;
   localparam int IDX_HOT   = 4;
   localparam int NUM_IN    = 5;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;

endpackage

// File: rtl/ser_chan_sync.sv
module ser_chan_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ser_chan_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/ser_chan_edge.sv
module ser_chan_edge
   import ser_chan_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  level,
   output edge_t ev
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign ev.rise = level & ~prev_q;
   assign ev.fall = ~level & prev_q;

endmodule

// File: rtl/ser_chan_shift.sv
module ser_chan_shift #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              emit,
   input  logic              din,
   output logic [NUM_CH-1:0] shreg,
   output logic              sout
);

   localparam int TOP = NUM_CH - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    shreg <= '0;
      else if (step) shreg <= {shreg[TOP-1:0], din};
   end

   // cascade bit retimed to the serial clock fall for downstream setup margin
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sout <= 1'b0;
      else if (emit) sout <= shreg[TOP];
   end

endmodule

// File: rtl/ser_chan_hold.sv
module ser_chan_hold #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [NUM_CH-1:0] shreg,
   input  logic              shdn,
   input  logic              hot,
   output logic [NUM_CH-1:0] hold,
   output logic [NUM_CH-1:0] chan_on
);

   logic hot_eff;
   logic force_off;

   // shutdown masks the thermal flag; either one blanks the channels
   assign hot_eff   = hot & ~shdn;
   assign force_off = shdn | hot_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold <= '0;
      else if (load) hold <= shreg;
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chan_on[ch] <= 1'b0;
         else        chan_on[ch] <= hold[ch] & ~force_off;
      end
   end

endmodule

// File: rtl/ser_chan_ctrl.sv
module ser_chan_ctrl
   import ser_chan_pkg::*;
#(
   parameter int NUM_CH      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdata_i,
   input  logic              latch_i,
   input  logic              shdn_i,
   input  logic              hot_i,
   output logic [NUM_CH-1:0] chan_on_o,
   output logic              sdata_o
);

   if (NUM_CH < 2) begin : g_bad_width
      $error("ser_chan_ctrl: NUM_CH must be at least 2");
   end

   logic [NUM_IN-1:0] raw_in;
   logic [NUM_IN-1:0] syn_in;
   edge_t             sclk_ev;
   edge_t             latch_ev;
   logic              data_q;
   logic              shdn_q;
   logic              hot_q;
   logic [NUM_CH-1:0] shreg;
   logic [NUM_CH-1:0] hold;

   assign raw_in[IDX_SCLK]  = sclk_i;
   assign raw_in[IDX_DATA]  = sdata_i;
   assign raw_in[IDX_LATCH] = latch_i;
   assign raw_in[IDX_SHDN]  = shdn_i;
   assign raw_in[IDX_HOT]   = hot_i;

   ser_chan_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (raw_in),
      .sync_out (syn_in)
   );

   assign data_q = syn_in[IDX_DATA];
   assign shdn_q = syn_in[IDX_SHDN];
   assign hot_q  = syn_in[IDX_HOT];

   ser_chan_edge u_sclk_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (syn_in[IDX_SCLK]),
      .ev    (sclk_ev)
   );

   ser_chan_edge u_latch_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (syn_in[IDX_LATCH]),
      .ev    (latch_ev)
   );

   ser_chan_shift #(.NUM_CH(NUM_CH)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (sclk_ev.rise),
      .emit  (sclk_ev.fall),
      .din   (data_q),
      .shreg (shreg),
      .sout  (sdata_o)
   );

   ser_chan_hold #(.NUM_CH(NUM_CH)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (latch_ev.rise),
      .shreg   (shreg),
      .shdn    (shdn_q),
      .hot     (hot_q),
      .hold    (hold),
      .chan_on (chan_on_o)
   );

endmodule

// File: rtl/ser_chan_chk.sv
module ser_chan_chk #(
   parameter int NUM_CH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sclk_rise,
   input logic              sclk_fall,
   input logic              latch_rise,
   input logic              data_q,
   input logic              shdn_q,
   input logic              hot_q,
   input logic [NUM_CH-1:0] shreg,
   input logic [NUM_CH-1:0] hold,
   input logic [NUM_CH-1:0] chan_on,
   input logic              sout
);

   p_shift_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> shreg == {$past(shreg[NUM_CH-2:0]), $past(data_q)});

   p_hold_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_rise |=> $stable(hold));

   p_hold_preshift_r9: assert property (@(posedge clk) disable iff (!rst_n)
      latch_rise |=> hold == $past(shreg));

   p_shdn_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      shdn_q |=> chan_on == '0);

   p_hot_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hot_q |=> chan_on == '0);

   p_sout_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_fall |=> $stable(sout));

   p_sout_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_fall |=> sout == $past(shreg[NUM_CH-1]));

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_clear_r5: assert (chan_on == '0 && hold == '0 && shreg == '0 && sout == 1'b0);
      end
   end

endmodule

bind ser_chan_ctrl ser_chan_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sclk_rise  (sclk_ev.rise),
   .sclk_fall  (sclk_ev.fall),
   .latch_rise (latch_ev.rise),
   .data_q     (data_q),
   .shdn_q     (shdn_q),
   .hot_q      (hot_q),
   .shreg      (shreg),
   .hold       (hold),
   .chan_on    (chan_on_o),
   .sout       (sdata_o)
);

// File: tb/tb_ser_chan_ctrl.sv
module tb_ser_chan_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       sdata = 1'b0;
   logic       latch = 1'b0;
   logic       shdn = 1'b0;
   logic       hot = 1'b0;
   logic [7:0] chan_a;
   logic [7:0] chan_b;
   logic       sout_a;
   logic       sout_b;
   int         n_tests = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   ser_chan_ctrl dut (
      .clk (clk), .rst_n (rst_n), .sclk_i (sclk), .sdata_i (sdata),
      .latch_i (latch), .shdn_i (shdn), .hot_i (hot),
      .chan_on_o (chan_a), .sdata_o (sout_a)
   );

   // downstream device of a two-deep chain
   ser_chan_ctrl dut_b (
      .clk (clk), .rst_n (rst_n), .sclk_i (sclk), .sdata_i (sout_a),
      .latch_i (latch), .shdn_i (shdn), .hot_i (hot),
      .chan_on_o (chan_b), .sdata_o (sout_b)
   );

   // {data[7:0], shdn, hot, expected[7:0]}
   localparam logic [17:0] VEC [6] = '{
      {8'hA5, 1'b0, 1'b0, 8'hA5},
      {8'h3C, 1'b1, 1'b0, 8'h00},
      {8'hFF, 1'b0, 1'b1, 8'h00},
      {8'h81, 1'b1, 1'b1, 8'h00},
      {8'h01, 1'b0, 1'b0, 8'h01},
      {8'h80, 1'b0, 1'b0, 8'h80}
   };

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic shift_bit(input logic b);
      sdata = b;
      wait_n(4);
      sclk = 1'b1;
      wait_n(8);
      sclk = 1'b0;
      wait_n(4);
   endtask

   task automatic shift_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) shift_bit(v[i]);
   endtask

   task automatic pulse_latch();
      latch = 1'b1;
      wait_n(8);
      latch = 1'b0;
      wait_n(8);
   endtask

   initial begin
      wait_n(1);
      // R5: reset state
      wait_n(3);
      chk("R5 reset chan", chan_a, 8'h00);
      chk("R5 reset sout", {7'd0, sout_a}, 8'h00);
      rst_n = 1'b1;
      wait_n(4);

      // vector walk: R1 R2 R4 R6 R7
      for (int v = 0; v < 6; v++) begin
         shdn = VEC[v][9];
         hot  = VEC[v][8];
         shift_byte(VEC[v][17:10]);
         pulse_latch();
         chk("R2 R4 R6 R7 vector", chan_a, VEC[v][7:0]);
         shdn = 1'b0;
         hot  = 1'b0;
         wait_n(4);
      end

      // R4: held value reappears once gates drop (last vector 0x80)
      chk("R4 held 80", chan_a, 8'h80);

      // R1/R2: single bit order, first bit -> channel 7
      shift_byte(8'h5A);
      pulse_latch();
      chk("R1 R2 load 5A", chan_a, 8'h5A);

      // R3: shifting without latch leaves outputs
      shift_byte(8'hFF);
      chk("R3 no latch", chan_a, 8'h5A);
      pulse_latch();
      chk("R3 latch FF", chan_a, 8'hFF);
      shift_byte(8'h5A);
      pulse_latch();

      // R6: shutdown PWM pulse
      shdn = 1'b1;
      wait_n(3);
      chk("R6 shdn off", chan_a, 8'h00);
      shdn = 1'b0;
      wait_n(3);
      chk("R6 shdn release", chan_a, 8'h5A);

      // R7: thermal flag, auto resume, masked by shutdown
      hot = 1'b1;
      wait_n(3);
      chk("R7 hot off", chan_a, 8'h00);
      shdn = 1'b1;
      wait_n(3);
      hot = 1'b0;
      wait_n(4);
      chk("R7 hot masked under shdn", chan_a, 8'h00);
      shdn = 1'b0;
      wait_n(4);
      chk("R7 resume", chan_a, 8'h5A);

      // R9: simultaneous clock and latch rise
      shift_byte(8'h3C);
      sdata = 1'b1;
      wait_n(4);
      sclk  = 1'b1;
      latch = 1'b1;
      wait_n(8);
      sclk  = 1'b0;
      latch = 1'b0;
      wait_n(8);
      chk("R9 pre-shift load", chan_a, 8'h3C);
      pulse_latch();
      chk("R9 post-shift value", chan_a, 8'h79);

      // R5: reset mid-operation
      rst_n = 1'b0;
      wait_n(2);
      chk("R5 mid reset chan", chan_a, 8'h00);
      rst_n = 1'b1;
      wait_n(4);
      pulse_latch();
      chk("R5 shift cleared", chan_a, 8'h00);

      // R8: serial out only moves on the clock fall
      shift_bit(1'b1);
      for (int i = 0; i < 6; i++) shift_bit(1'b0);
      chk("R8 top bit low", {7'd0, sout_a}, 8'h00);
      sdata = 1'b0;
      wait_n(4);
      sclk = 1'b1;
      wait_n(8);
      chk("R8 unchanged before fall", {7'd0, sout_a}, 8'h00);
      sclk = 1'b0;
      wait_n(6);
      chk("R8 updated after fall", {7'd0, sout_a}, 8'h01);

      // R10: two chained devices, 16 clocks then one latch
      rst_n = 1'b0;
      wait_n(2);
      rst_n = 1'b1;
      wait_n(4);
      shift_byte(8'hC3);
      shift_byte(8'hA5);
      pulse_latch();
      chk("R10 downstream", chan_b, 8'hC3);
      chk("R10 upstream", chan_a, 8'hA5);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule